// File: doc/BRIEF.md
# Multi-Mode Pulse-Width Modulator

This block drives one pulse-width-modulated output from a 100 MHz clock, so one tick is 10 ns. A three-bit mode input selects how the pin behaves: held low, a fixed 256-tick period with an 8-bit duty, a fast mode that emits one-tick pulses whose repetition rate follows the duty, or a variable-frequency mode with separately programmed 13-bit low and high phase lengths. Mode codes 0 and 4 through 7 all mean "held low".

The mode, duty and phase-length inputs are sampled continuously, but the running waveform only picks them up at the end of its current period. This avoids runt pulses. Requesting the held-low mode is the one exception: it acts on the next clock edge. The waveform is made by a single state machine with the states IDLE (output low, reloads every cycle), STD (standard period), FAST (pulse train), VLO (variable-frequency low phase) and VHI (variable-frequency high phase).

The state machine has these transitions:
- any state to IDLE when the off mode is requested (OFF_REQ)
- IDLE, or a running state at its period end, to the state of the requested mode (RELOAD)
- VLO to VHI when the low phase is complete (PHASE_FLIP)
- STD and FAST stay in place and advance their counter (COUNT)

Top module: `pwm_multimode`

## Requirements
- R1: While rst_n is low, pwm_out is 0. After release with the off mode applied, it stays 0.
- R2: Mode codes 0, 4, 5, 6 and 7 all hold pwm_out at 0, whatever the duty and phase inputs are.
- R3: Mode 1 (standard) has a 256-tick period with exactly D high ticks per period for duty D. D=0 gives a constant low, and D=255 still gives one low tick per period.
- R4: Mode 2 (fast) with 1 ≤ D ≤ 128 gives a low background with a single one-tick high pulse every round(256/D) ticks (halves round up).
- R5: Mode 2 with 129 ≤ D ≤ 254 gives a high background with a single one-tick low pulse every round(256/(256−D)) ticks.
- R6: Mode 2 gives a constant low output for D=0 and a constant high output for D=255.
- R7: Mode 3 (variable frequency) gives a low phase of L+1 ticks followed by a high phase of H+1 ticks, for L and H in 0..8191. L=H=0 toggles every tick, and L=H=8191 gives a 16384-tick period.
- R8: A new duty, phase length or running mode is applied only at the end of the current period, so every high and low run belongs entirely to either the old setting or the new one.
- R9: Presenting an off code makes pwm_out 0 from the first clock edge at which that code is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | 0 off, 1 standard, 2 fast, 3 variable frequency, 4..7 off |
| duty_in | input | 8 | Duty value for standard and fast modes |
| lo_len | input | 13 | Low phase length minus one, in ticks |
| hi_len | input | 13 | High phase length minus one, in ticks |
| pwm_out | output | 1 | Modulated output pin |

## Verification
The hardest situation to reach from the ports is a settings change that lands in the middle of a running period. Observing that change requires knowing both the old and the new run lengths, and seeing the boundary between them. The stimulus settles a standard waveform at duty 200, then switches the duty to 10 at an arbitrary point. It records every completed high and low run across the change, and requires each run to be exactly one of the four lengths that whole periods can produce. The other settings are measured without relying on phase alignment: for each one, the bench counts high ticks and rising edges over a window that is a whole number of periods.

// File: rtl/pwm_mm_pkg.sv
package pwm_mm_pkg;

    typedef enum logic [2:0] {
        MD_OFF  = 3'd0,
        MD_STD  = 3'd1,
        MD_FAST = 3'd2,
        MD_VAR  = 3'd3,
        MD_SOFT = 3'd4
    } pwm_mode_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_STD  = 3'd1,
        S_FAST = 3'd2,
        S_VLO  = 3'd3,
        S_VHI  = 3'd4
    } pwm_state_e;

    function automatic logic mode_is_off(input logic [2:0] m);
        return !((m == MD_STD) || (m == MD_FAST) || (m == MD_VAR));
    endfunction

    function automatic pwm_state_e mode_entry_state(input logic [2:0] m);
        pwm_state_e s;
        unique case (m)
            MD_STD:  s = S_STD;
            MD_FAST: s = S_FAST;
            MD_VAR:  s = S_VLO;
            default: s = S_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwm_fast_rate.sv
module pwm_fast_rate #(
    parameter int DUTY_W = 8
) (
    input  logic [DUTY_W-1:0] duty,
    output logic [DUTY_W:0]   interval,
    output logic              background,
    output logic              pulse_en
);
    localparam int FULL = 1 << DUTY_W;
    localparam int HALF = FULL / 2;
    localparam int NW   = DUTY_W + 2;

    logic [DUTY_W-1:0] minority;
    logic [NW-1:0]     numer;
    logic [NW-1:0]     denom;
    logic [NW:0]       rem;
    logic [NW-1:0]     quot;

    // Pick background level and the count of minority ticks per 256.
    always_comb begin
        if (duty == '0) begin
            background = 1'b0;
            pulse_en   = 1'b0;
            minority   = DUTY_W'(1);
        end else if (duty == {DUTY_W{1'b1}}) begin
            background = 1'b1;
            pulse_en   = 1'b0;
            minority   = DUTY_W'(1);
        end else if (int'(duty) <= HALF) begin
            background = 1'b0;
            pulse_en   = 1'b1;
            minority   = duty;
        end else begin
            background = 1'b1;
            pulse_en   = 1'b1;
            minority   = DUTY_W'(FULL - int'(duty));
        end
    end

    // Rounded interval: (2*FULL + m) / (2*m), restoring division.
    always_comb begin
        numer = NW'(2 * FULL) + NW'(minority);
        denom = NW'(minority) << 1;
        rem   = '0;
        quot  = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            rem = {rem[NW-1:0], numer[i]};
            if (rem >= {1'b0, denom}) begin
                rem     = rem - {1'b0, denom};
                quot[i] = 1'b1;
            end
        end
    end

    // Constant-level settings use a full 256-tick frame.
    always_comb begin
        if (pulse_en) interval = quot[DUTY_W:0];
        else          interval = (DUTY_W+1)'(FULL);
    end

endmodule

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank #(
    parameter int DUTY_W = 8,
    parameter int PER_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DUTY_W-1:0] req_duty,
    input  logic [PER_W-1:0]  req_lo,
    input  logic [PER_W-1:0]  req_hi,
    input  logic [DUTY_W:0]   req_interval,
    input  logic              req_bg,
    input  logic              req_pulse,
    output logic [DUTY_W-1:0] act_duty,
    output logic [PER_W-1:0]  act_lo,
    output logic [PER_W-1:0]  act_hi,
    output logic [DUTY_W:0]   act_interval,
    output logic              act_bg,
    output logic              act_pulse
);
    localparam int FULL = 1 << DUTY_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_duty     <= '0;
            act_lo       <= '0;
            act_hi       <= '0;
            act_interval <= (DUTY_W+1)'(FULL);
            act_bg       <= 1'b0;
            act_pulse    <= 1'b0;
        end else if (load) begin
            act_duty     <= req_duty;
            act_lo       <= req_lo;
            act_hi       <= req_hi;
            act_interval <= req_interval;
            act_bg       <= req_bg;
            act_pulse    <= req_pulse;
        end
    end

endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
    import pwm_mm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int PER_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        req_mode,
    input  logic [DUTY_W-1:0] act_duty,
    input  logic [PER_W-1:0]  act_lo,
    input  logic [PER_W-1:0]  act_hi,
    input  logic [DUTY_W:0]   act_interval,
    input  logic              act_bg,
    input  logic              act_pulse,
    output logic              load,
    output pwm_state_e        state,
    output logic              pwm_out
);
    localparam int FULL  = 1 << DUTY_W;
    localparam int CNT_W = (PER_W > DUTY_W + 1) ? PER_W : DUTY_W + 1;

    pwm_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             out_q, out_d;
    logic             req_off;
    logic             period_end;

    assign req_off = mode_is_off(req_mode);

    // Last tick of the running period for each state.
    always_comb begin
        unique case (st_q)
            S_STD:   period_end = (cnt_q == CNT_W'(FULL - 1));
            S_FAST:  period_end = (cnt_q == CNT_W'(act_interval) - CNT_W'(1));
            S_VHI:   period_end = (cnt_q == CNT_W'(act_hi));
            default: period_end = 1'b0;
        endcase
    end

    assign load = (st_q == S_IDLE) || period_end;

    // Next-state and counter logic.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + CNT_W'(1);
        if (req_off) begin
            st_d  = S_IDLE;                       // OFF_REQ
            cnt_d = '0;
        end else if (load) begin
            st_d  = mode_entry_state(req_mode);   // RELOAD
            cnt_d = '0;
        end else if (st_q == S_VLO && cnt_q == CNT_W'(act_lo)) begin
            st_d  = S_VHI;                        // PHASE_FLIP
            cnt_d = '0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output decode.
    always_comb begin
        unique case (st_q)
            S_IDLE:  out_d = 1'b0;
            S_STD:   out_d = (cnt_q < CNT_W'(act_duty));
            S_FAST:  out_d = (act_pulse && cnt_q == '0) ? ~act_bg : act_bg;
            S_VLO:   out_d = 1'b0;
            S_VHI:   out_d = 1'b1;
            default: out_d = 1'b0;
        endcase
        if (req_off) out_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign state   = st_q;
    assign pwm_out = out_q;

endmodule

// File: rtl/pwm_multimode.sv
module pwm_multimode
    import pwm_mm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int PER_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic [PER_W-1:0]  lo_len,
    input  logic [PER_W-1:0]  hi_len,
    output logic              pwm_out
);
    logic [DUTY_W:0]   rate_interval;
    logic              rate_bg;
    logic              rate_pulse;
    logic [DUTY_W-1:0] act_duty;
    logic [PER_W-1:0]  act_lo;
    logic [PER_W-1:0]  act_hi;
    logic [DUTY_W:0]   act_interval;
    logic              act_bg;
    logic              act_pulse;
    logic              load;
    pwm_state_e        st_q;

    pwm_fast_rate #(.DUTY_W(DUTY_W)) u_rate (
        .duty       (duty_in),
        .interval   (rate_interval),
        .background (rate_bg),
        .pulse_en   (rate_pulse)
    );

    pwm_cfg_bank #(.DUTY_W(DUTY_W), .PER_W(PER_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .req_duty     (duty_in),
        .req_lo       (lo_len),
        .req_hi       (hi_len),
        .req_interval (rate_interval),
        .req_bg       (rate_bg),
        .req_pulse    (rate_pulse),
        .act_duty     (act_duty),
        .act_lo       (act_lo),
        .act_hi       (act_hi),
        .act_interval (act_interval),
        .act_bg       (act_bg),
        .act_pulse    (act_pulse)
    );

    pwm_seq #(.DUTY_W(DUTY_W), .PER_W(PER_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_mode     (mode_sel),
        .act_duty     (act_duty),
        .act_lo       (act_lo),
        .act_hi       (act_hi),
        .act_interval (act_interval),
        .act_bg       (act_bg),
        .act_pulse    (act_pulse),
        .load         (load),
        .state        (st_q),
        .pwm_out      (pwm_out)
    );

endmodule

// File: rtl/pwm_multimode_chk.sv
module pwm_multimode_chk
    import pwm_mm_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_sel,
    input logic              pwm_out,
    input pwm_state_e        state,
    input logic [DUTY_W-1:0] act_duty,
    input logic              load
);
    logic off_code;
    assign off_code = (mode_sel == 3'd0) || (mode_sel > 3'd3);

    // R9 and R2: an off code forces the pin low after the edge that samples it
    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        off_code |=> !pwm_out);

    // R3: standard mode with zero duty never drives high
    p_std_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STD && act_duty == '0) |=> !pwm_out);

    // R6: fast mode at full duty stays high
    p_fast_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FAST && act_duty == {DUTY_W{1'b1}} && !off_code) |=> pwm_out);

    // R7: low phase drives low, high phase drives high
    p_var_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VLO) |=> !pwm_out);
    p_var_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VHI && !off_code) |=> pwm_out);

    // R8: active settings move only after a period boundary or idle reload
    p_load_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_duty) |-> $past(load));

endmodule

bind pwm_multimode pwm_multimode_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .pwm_out  (pwm_out),
    .state    (st_q),
    .act_duty (act_duty),
    .load     (load)
);

// File: tb/pwm_multimode_tb.sv
module pwm_multimode_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;

    typedef struct packed {
        logic [2:0]  mode;
        logic [7:0]  duty;
        logic [12:0] lo;
        logic [12:0] hi;
        logic [15:0] win;
        logic [15:0] highs;
        logic [15:0] rises;
        logic [3:0]  req;
    } vec_t;

    // mode, duty, lo, hi, window, expected highs, expected rising edges, requirement
    localparam logic [88:0] VEC [NVEC] = '{
        {3'd1, 8'd0,   13'd0,  13'd0, 16'd256, 16'd0,   16'd0,   4'd3}, // R3 zero duty
        {3'd1, 8'd1,   13'd0,  13'd0, 16'd256, 16'd1,   16'd1,   4'd3}, // R3
        {3'd1, 8'd128, 13'd0,  13'd0, 16'd256, 16'd128, 16'd1,   4'd3}, // R3
        {3'd1, 8'd255, 13'd0,  13'd0, 16'd256, 16'd255, 16'd1,   4'd3}, // R3 never constant high
        {3'd2, 8'd1,   13'd0,  13'd0, 16'd512, 16'd2,   16'd2,   4'd4}, // R4 interval 256
        {3'd2, 8'd64,  13'd0,  13'd0, 16'd256, 16'd64,  16'd64,  4'd4}, // R4 interval 4
        {3'd2, 8'd128, 13'd0,  13'd0, 16'd256, 16'd128, 16'd128, 4'd4}, // R4 interval 2
        {3'd2, 8'd3,   13'd0,  13'd0, 16'd255, 16'd3,   16'd3,   4'd4}, // R4 interval 85
        {3'd2, 8'd100, 13'd0,  13'd0, 16'd300, 16'd100, 16'd100, 4'd4}, // R4 interval 3
        {3'd2, 8'd192, 13'd0,  13'd0, 16'd256, 16'd192, 16'd64,  4'd5}, // R5 interval 4
        {3'd2, 8'd129, 13'd0,  13'd0, 16'd256, 16'd128, 16'd128, 4'd5}, // R5 interval 2
        {3'd2, 8'd254, 13'd0,  13'd0, 16'd256, 16'd254, 16'd2,   4'd5}, // R5 interval 128
        {3'd2, 8'd0,   13'd0,  13'd0, 16'd300, 16'd0,   16'd0,   4'd6}, // R6 const low
        {3'd2, 8'd255, 13'd0,  13'd0, 16'd300, 16'd300, 16'd0,   4'd6}, // R6 const high
        {3'd3, 8'd0,   13'd0,  13'd0, 16'd256, 16'd128, 16'd128, 4'd7}, // R7 toggle
        {3'd3, 8'd0,   13'd2,  13'd5, 16'd90,  16'd60,  16'd10,  4'd7}, // R7 period 9
        {3'd3, 8'd0,   13'd99, 13'd0, 16'd202, 16'd2,   16'd2,   4'd7}, // R7 period 101
        {3'd4, 8'd128, 13'd3,  13'd3, 16'd256, 16'd0,   16'd0,   4'd2}, // R2 code 4
        {3'd7, 8'd200, 13'd3,  13'd3, 16'd256, 16'd0,   16'd0,   4'd2}  // R2 code 7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'd1;
    logic [7:0]  duty_in = 8'd255;
    logic [12:0] lo_len = '0;
    logic [12:0] hi_len = '0;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_multimode u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .duty_in  (duty_in),
        .lo_len   (lo_len),
        .hi_len   (hi_len),
        .pwm_out  (pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int win, output int highs, output int rises);
        logic prev;
        prev  = pwm_out;
        highs = 0;
        rises = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
    endtask

    task automatic go_off();
        @(negedge clk);
        mode_sel = 3'd0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int h, r;
        vec_t v;

        // R1: low during reset even with a full-duty mode requested
        repeat (4) @(negedge clk);
        check(pwm_out == 1'b0, "R1 in reset", int'(pwm_out), 0);
        mode_sel = 3'd0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(pwm_out == 1'b0, "R1 after release", int'(pwm_out), 0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            v = vec_t'(VEC[i]);
            go_off();
            mode_sel = v.mode;
            duty_in  = v.duty;
            lo_len   = v.lo;
            hi_len   = v.hi;
            repeat (4) @(negedge clk);
            measure(int'(v.win), h, r);
            check(h == int'(v.highs), $sformatf("R%0d vec%0d highs", v.req, i), h, int'(v.highs));
            check(r == int'(v.rises), $sformatf("R%0d vec%0d rises", v.req, i), r, int'(v.rises));
        end

        // R7: longest phases, 16384-tick period
        go_off();
        mode_sel = 3'd3;
        lo_len   = 13'd8191;
        hi_len   = 13'd8191;
        repeat (4) @(negedge clk);
        measure(16384, h, r);
        check(h == 8192, "R7 max highs", h, 8192);
        check(r == 1, "R7 max rises", r, 1);

        // R8: duty change in mid-period, every run must be a whole-period run
        begin
            int hi_run_bad, lo_run_bad, run, seen_new, first;
            logic lvl;
            go_off();
            mode_sel = 3'd1;
            duty_in  = 8'd200;
            repeat (603) @(negedge clk);
            hi_run_bad = 0; lo_run_bad = 0; seen_new = 0; first = 1;
            lvl = pwm_out;
            run = 1;
            for (int k = 0; k < 1500; k++) begin
                @(negedge clk);
                if (k == 101) duty_in = 8'd10;
                if (pwm_out == lvl) begin
                    run++;
                end else begin
                    if (!first) begin
                        if (lvl && !(run == 200 || run == 10)) hi_run_bad++;
                        if (!lvl && !(run == 56 || run == 246)) lo_run_bad++;
                        if (lvl && run == 10) seen_new++;
                    end
                    first = 0;
                    lvl = pwm_out;
                    run = 1;
                end
            end
            check(hi_run_bad == 0, "R8 high run lengths", hi_run_bad, 0);
            check(lo_run_bad == 0, "R8 low run lengths", lo_run_bad, 0);
            check(seen_new > 0, "R8 new duty applied", seen_new, 1);
        end

        // R9: off acts at the first sampling edge
        go_off();
        mode_sel = 3'd1;
        duty_in  = 8'd255;
        repeat (10) @(negedge clk);
        while (!pwm_out) @(negedge clk);
        check(pwm_out == 1'b1, "R9 precondition high", int'(pwm_out), 1);
        mode_sel = 3'd0;
        @(negedge clk);
        check(pwm_out == 1'b0, "R9 immediate off", int'(pwm_out), 0);
        measure(50, h, r);
        check(h == 0, "R9 stays off", h, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule